// File: doc/BRIEF.md
# CEC Frame Receiver with Address Filter

The block watches a single-wire consumer-electronics-control line, recovers the start bit and the ten-bit byte cells that follow (eight data bits sent most significant first, an end-of-message bit, and an acknowledge slot), and keeps the bytes of frames meant for this node in a small receive array. The low nibble of the first byte (the header) is the destination address. A frame is accepted when that destination is set in a 16-bit one-hot table of claimed logical addresses, or when it is 15 (broadcast). Frames for other destinations are still tracked bit by bit, so framing stays in step, but they leave the array and the done flag alone.

For an accepted direct frame the block pulls the line low through the acknowledge slot of each stored byte. For broadcast it leaves the slot high, and pulls it low only to reject a byte it had to drop. Timing is measured in clock cycles scaled by `CLK_PER_UNIT` (cycles per 0.1 ms). Each timing violation sets its own sticky flag, and the frame is abandoned.

Top module: `cec_rx`

## Requirements
- R1: After reset `flags_o`, `arr_sts_o` and `cec_drive_o` are all zero.
- R2: An accepted frame stores its bytes in order at indices 0.., with the byte count in `arr_sts_o[4:0]`. `flags_o` bit 1 (start-of-message) sets when the header is accepted, bit 2 (end-of-message) sets when an accepted byte carries EOM=1, and bit 0 (done) sets 2.1 ms into the final acknowledge slot.
- R3: For an accepted direct frame `cec_drive_o` is high for 1.5 ms from the falling edge of the acknowledge slot of every stored byte. For broadcast it stays low in the slots of stored bytes.
- R4: A header whose destination is 15 is accepted whatever `addr_mask_i` holds.
- R5: A frame whose destination bit in `addr_mask_i` is clear (including a mask of zero) stores nothing. It leaves the byte count, the done flag and the start-of-message flag unchanged and never drives the line.
- R6: With 16 bytes held, a further byte of the same frame is dropped and sets `arr_sts_o[6]` (overrun). A direct frame gives no acknowledge for that byte; a broadcast frame acknowledges only that byte.
- R7: A start bit whose cell exceeds 4.7 ms sets `flags_o` bit 3.
- R8: Inside a frame, a data bit cell that reaches 2.8 ms with no next falling edge sets `flags_o` bit 4.
- R9: A low pulse shorter than 0.3 ms sets `flags_o` bit 5. A high pulse shorter than 0.3 ms sets bit 6.
- R10: A bit period below 2.1 ms sets `flags_o` bit 7 and one above 2.6 ms sets bit 8. Either one abandons the frame with no done flag.
- R11: With `filt_en_i` high, a line glitch shorter than `FILT_LEN` cycles is ignored. With it low, the same glitch is decoded and reported as a short low pulse.
- R12: A one-cycle pulse on `clr_i` clears all bits of `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cec_i | input | 1 | Sensed line level (1 = released) |
| filt_en_i | input | 1 | Enables the input glitch filter |
| addr_mask_i | input | 16 | One-hot claimed logical addresses |
| clr_i | input | 1 | Clears the status flags |
| rd_idx_i | input | 4 | Receive array read index |
| rd_data_o | output | 8 | Receive array byte at rd_idx_i |
| arr_sts_o | output | 8 | [4:0] byte count, [6] overrun |
| flags_o | output | 9 | Sticky status: done, som, eom, start/data timeouts, pulse and period errors |
| cec_drive_o | output | 1 | 1 pulls the line low (acknowledge) |

## Verification
The filtered line trails `cec_i` by three cycles with the filter off and by 2+`FILT_LEN` cycles with it on. Each flag and array update lands one cycle after the filtered edge or sample point that causes it, so results are due a few cycles after the line event. The bench drives the line on falling clock edges and reads status only after the frame's last cell plus several units of idle. It samples the acknowledge drive 8 units into each acknowledge slot, well inside the 1.5 ms pulse that starts four cycles after the slot's falling edge.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SLO, ST_SHI, ST_BIT, ST_ABORT
  } rx_state_e;

  localparam int FL_W      = 9;
  localparam int FL_DONE   = 0;
  localparam int FL_SOM    = 1;
  localparam int FL_EOM    = 2;
  localparam int FL_STOUT  = 3;
  localparam int FL_DTOUT  = 4;
  localparam int FL_LPULSE = 5;
  localparam int FL_HPULSE = 6;
  localparam int FL_PSHORT = 7;
  localparam int FL_PLONG  = 8;
endpackage

// File: rtl/cec_rx_filter.sv
module cec_rx_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic line_o
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic          sync1, sync2;
  logic [FW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      line_o <= 1'b1;
      cnt    <= '0;
    end else begin
      sync1 <= line_i;
      sync2 <= sync1;
      if (!en_i) begin
        line_o <= sync2;
        cnt    <= '0;
      end else if (sync2 == line_o) begin
        cnt <= '0;
      end else if (cnt == FW'(FILT_LEN - 1)) begin
        line_o <= sync2;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11
  filt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(sync2) == line_o));
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          first_i,
  input  logic [7:0]    data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovr_o,
  output logic          full_o
);
  logic [7:0] mem [DEPTH];

  assign full_o    = (cnt_o == CW'(DEPTH));
  assign rd_data_o = mem[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovr_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_i) begin
      if (first_i) begin
        mem[0] <= data_i;
        cnt_o  <= CW'(1);
        ovr_o  <= 1'b0;
      end else if (full_o) begin
        ovr_o <= 1'b1;
      end else begin
        mem[cnt_o[IW-1:0]] <= data_i;
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
  // R6
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> (cnt_o == CW'(DEPTH)) && ($past(cnt_o) == CW'(DEPTH)));
endmodule

// File: rtl/cec_rx_ack.sv
module cec_rx_ack #(
  parameter int ACK_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic drive_o
);
  localparam int AW = $clog2(ACK_CYC + 1);

  logic [AW-1:0] cnt;
  logic [AW:0]   run;

  assign drive_o = (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (go_i)     cnt <= AW'(ACK_CYC);
    else if (drive_o)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run <= '0;
    else if (drive_o) run <= run + 1'b1;
    else              run <= '0;
  end

  // R3
  ack_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run <= (AW+1)'(ACK_CYC));
endmodule

// File: rtl/cec_rx.sv
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int CLK_PER_UNIT = 2700,
  parameter int DEPTH        = 16,
  parameter int FILT_LEN     = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cec_i,
  input  logic        filt_en_i,
  input  logic [15:0] addr_mask_i,
  input  logic        clr_i,
  input  logic [3:0]  rd_idx_i,
  output logic [7:0]  rd_data_o,
  output logic [7:0]  arr_sts_o,
  output logic [8:0]  flags_o,
  output logic        cec_drive_o
);
  localparam int U    = CLK_PER_UNIT;
  localparam int TMAX = 64 * U;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int IW   = $clog2(DEPTH);
  localparam logic [TW-1:0] LP_MIN    = TW'(3 * U);
  localparam logic [TW-1:0] HP_MIN    = TW'(3 * U);
  localparam logic [TW-1:0] SLO_MIN   = TW'(35 * U);
  localparam logic [TW-1:0] SLO_MAX   = TW'(39 * U);
  localparam logic [TW-1:0] SPER_MIN  = TW'(43 * U);
  localparam logic [TW-1:0] SPER_MAX  = TW'(47 * U);
  localparam logic [TW-1:0] STOUT     = TW'(47 * U);
  localparam logic [TW-1:0] SAMPLE    = TW'((21 * U) / 2);
  localparam logic [TW-1:0] PER_MIN   = TW'(21 * U);
  localparam logic [TW-1:0] PER_MAX   = TW'(26 * U);
  localparam logic [TW-1:0] DTOUT     = TW'(28 * U);
  localparam logic [TW-1:0] DONE_T    = PER_MIN;
  localparam int            ACK_CYC   = 15 * U;

  rx_state_e     st_q, st_n;
  logic          ln, ln_q, fall, rise;
  logic [TW-1:0] cyc_fall, cyc_rise;
  logic [3:0]    bidx_q, bidx_n;
  logic [7:0]    sh_q, sh_n;
  logic          hdr_q, hdr_n, acc_q, acc_n, bc_q, bc_n, eom_q, eom_n, ackp_q, ackp_n;
  logic [FL_W-1:0] flags_q, fset;
  logic          wr, ack_go, full, ovr, a_now, b_now, drop;
  logic [CW-1:0] cnt;
  logic [3:0]    dest;

  cec_rx_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .en_i(filt_en_i), .line_i(cec_i), .line_o(ln)
  );

  cec_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_i(wr), .first_i(hdr_q), .data_i(sh_q),
    .rd_idx_i(rd_idx_i[IW-1:0]), .rd_data_o, .cnt_o(cnt), .ovr_o(ovr), .full_o(full)
  );

  cec_rx_ack #(.ACK_CYC(ACK_CYC)) u_ack (
    .clk_i, .rst_ni, .go_i(ack_go), .drive_o(cec_drive_o)
  );

  assign fall      = ln_q & ~ln;
  assign rise      = ~ln_q & ln;
  assign dest      = sh_q[3:0];
  assign flags_o   = flags_q;
  assign arr_sts_o = {1'b0, ovr, 1'b0, 5'(cnt)};
  assign a_now     = hdr_q ? (addr_mask_i[dest] | (dest == 4'hF)) : acc_q;
  assign b_now     = hdr_q ? (dest == 4'hF) : bc_q;
  assign drop      = ~hdr_q & full;

  always_comb begin
    st_n = st_q; bidx_n = bidx_q; sh_n = sh_q; hdr_n = hdr_q; acc_n = acc_q;
    bc_n = bc_q; eom_n = eom_q; ackp_n = ackp_q; fset = '0; wr = 1'b0; ack_go = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fall) st_n = ST_SLO;
      ST_SLO: begin
        if (rise) begin
          if (cyc_fall < LP_MIN) begin
            fset[FL_LPULSE] = 1'b1;
            st_n = ST_IDLE;
          end else if (cyc_fall >= SLO_MIN && cyc_fall <= SLO_MAX) st_n = ST_SHI;
          else st_n = ST_IDLE;
        end else if (cyc_fall >= STOUT) begin
          fset[FL_STOUT] = 1'b1;
          st_n = ST_ABORT;
        end
      end
      ST_SHI: begin
        if (fall) begin
          if (cyc_rise < HP_MIN) begin
            fset[FL_HPULSE] = 1'b1;
            st_n = ST_ABORT;
          end else if (cyc_fall >= SPER_MIN && cyc_fall <= SPER_MAX) begin
            st_n = ST_BIT; bidx_n = '0; hdr_n = 1'b1; acc_n = 1'b0;
            bc_n = 1'b0; eom_n = 1'b0; ackp_n = 1'b0;
          end else st_n = ST_SLO;
        end else if (cyc_fall >= STOUT) begin
          fset[FL_STOUT] = 1'b1;
          st_n = ST_IDLE;
        end
      end
      ST_BIT: begin
        if (rise && cyc_fall < LP_MIN) begin
          fset[FL_LPULSE] = 1'b1;
          st_n = ST_ABORT;
        end else if (fall) begin
          if (cyc_rise < HP_MIN) begin
            fset[FL_HPULSE] = 1'b1; st_n = ST_ABORT;
          end else if (cyc_fall < PER_MIN) begin
            fset[FL_PSHORT] = 1'b1; st_n = ST_ABORT;
          end else if (cyc_fall > PER_MAX) begin
            fset[FL_PLONG] = 1'b1; st_n = ST_ABORT;
          end else begin
            bidx_n = (bidx_q == 4'd9) ? 4'd0 : bidx_q + 4'd1;
            ack_go = (bidx_q == 4'd8) && ackp_q;
          end
        end else if (cyc_fall == SAMPLE) begin
          if (bidx_q < 4'd8) sh_n = {sh_q[6:0], ln};
          else if (bidx_q == 4'd8) begin
            eom_n  = ln;
            hdr_n  = 1'b0;
            acc_n  = a_now;
            bc_n   = b_now;
            wr     = a_now;
            ackp_n = a_now && (b_now ? drop : !drop);
            fset[FL_SOM] = hdr_q & a_now;
            fset[FL_EOM] = a_now & ln;
          end
        end else if (bidx_q == 4'd9 && eom_q && cyc_fall == DONE_T) begin
          fset[FL_DONE] = acc_q;
          st_n = ST_IDLE;
        end else if (cyc_fall == DTOUT) begin
          fset[FL_DTOUT] = 1'b1;
          st_n = ST_ABORT;
        end
      end
      ST_ABORT: if (ln) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ln_q <= 1'b1; cyc_fall <= '0; cyc_rise <= '0;
      bidx_q <= '0; sh_q <= '0; hdr_q <= 1'b0; acc_q <= 1'b0; bc_q <= 1'b0;
      eom_q <= 1'b0; ackp_q <= 1'b0; flags_q <= '0;
    end else begin
      st_q <= st_n; ln_q <= ln;
      cyc_fall <= fall ? TW'(1) : ((cyc_fall == TW'(TMAX)) ? cyc_fall : cyc_fall + 1'b1);
      cyc_rise <= rise ? TW'(1) : ((cyc_rise == TW'(TMAX)) ? cyc_rise : cyc_rise + 1'b1);
      bidx_q <= bidx_n; sh_q <= sh_n; hdr_q <= hdr_n; acc_q <= acc_n; bc_q <= bc_n;
      eom_q <= eom_n; ackp_q <= ackp_n;
      flags_q <= (clr_i ? '0 : flags_q) | fset;
    end
  end

  // R3
  ack_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cec_drive_o) |-> (bidx_q == 4'd9) && (st_q == ST_BIT));
  // R2
  done_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[FL_DONE]) |-> $past(acc_q) && (st_q == ST_IDLE));
  // R10
  per_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flags_q[FL_PSHORT]) || $rose(flags_q[FL_PLONG])) |-> (st_q == ST_ABORT));
endmodule

// File: tb/tb_cec_rx.sv
module tb_cec_rx;
  localparam int U = 4;

  logic clk = 1'b0, rst_n = 1'b0, tx_low = 1'b0, filt = 1'b0, clr = 1'b0;
  logic [15:0] mask = '0;
  logic [3:0]  rd_idx = '0;
  logic [7:0]  rd_data, arr_sts;
  logic [8:0]  flags;
  logic        drv, line;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] fb [0:19];
  bit ack_seen [0:19];

  assign line = !(tx_low || drv);
  always #2 clk = ~clk;

  cec_rx #(.CLK_PER_UNIT(U)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cec_i(line), .filt_en_i(filt), .addr_mask_i(mask),
    .clr_i(clr), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .arr_sts_o(arr_sts),
    .flags_o(flags), .cec_drive_o(drv)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_u(input int n); repeat (n * U) @(negedge clk); endtask
  task automatic bit_tx(input int lo, input int per);
    tx_low = 1'b1; wait_u(lo); tx_low = 1'b0; wait_u(per - lo);
  endtask
  task automatic byte_tx(input logic [7:0] b, input bit eom, output bit ak);
    for (int i = 7; i >= 0; i--) bit_tx(b[i] ? 6 : 15, 24);
    bit_tx(eom ? 6 : 15, 24);
    tx_low = 1'b1; wait_u(6); tx_low = 1'b0; wait_u(2); ak = drv; wait_u(16);
  endtask
  task automatic frame_tx(input int len);
    bit_tx(37, 45);
    for (int i = 0; i < len; i++) byte_tx(fb[i], i == len - 1, ack_seen[i]);
    wait_u(6);
  endtask
  task automatic do_clr; @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; endtask
  task automatic rd(input int idx, output logic [7:0] d);
    rd_idx = idx[3:0]; #1; d = rd_data;
  endtask

  function automatic bit exp_acc(input logic [15:0] m, input logic [3:0] d);
    return (d == 4'hF) || m[d];
  endfunction
  function automatic bit exp_ack(input bit acc, input bit bc, input int i);
    return acc && (bc ? (i >= 16) : (i < 16));
  endfunction

  task automatic check_frame(input string req, input int len, input int cnt_before);
    logic [7:0] d;
    bit acc, bc;
    int n;
    acc = exp_acc(mask, fb[0][3:0]);
    bc  = (fb[0][3:0] == 4'hF);
    n   = acc ? ((len > 16) ? 16 : len) : cnt_before;
    chk({req, " count"}, int'(arr_sts[4:0]), n);
    chk({req, " overrun"}, int'(arr_sts[6]), (acc && len > 16) ? 1 : (acc ? 0 : int'(arr_sts[6])));
    chk({req, " flags"}, int'(flags), acc ? 9'h007 : 9'h000);
    if (acc) for (int i = 0; i < n; i++) begin
      rd(i, d);
      chk({req, " data"}, int'(d), int'(fb[i]));
    end
    for (int i = 0; i < len; i++) chk({req, " ack"}, int'(ack_seen[i]), int'(exp_ack(acc, bc, i)));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int cb;
    void'($urandom(32'd20250));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_u(2);
    // R1 reset state
    chk("R1 flags", int'(flags), 0);
    chk("R1 arr_sts", int'(arr_sts), 0);
    chk("R1 drive", int'(drv), 0);

    // R2 R3 direct claimed frame with filter on
    filt = 1'b1; mask = 16'h0010;
    fb[0] = 8'h14; fb[1] = 8'hA5; fb[2] = 8'h3C;
    frame_tx(3);
    check_frame("R2 R3 direct", 3, 0);
    filt = 1'b0;

    // R4 R3 broadcast with empty mask
    do_clr; mask = 16'h0000; fb[0] = 8'h2F; fb[1] = 8'h81;
    frame_tx(2);
    check_frame("R4 R3 broadcast", 2, 0);

    // R5 unclaimed destination, then released table
    do_clr; mask = 16'h0010; fb[0] = 8'h15; fb[1] = 8'h77;
    frame_tx(2);
    check_frame("R5 unclaimed", 2, 2);
    do_clr; mask = 16'h0000; fb[0] = 8'h14;
    frame_tx(2);
    check_frame("R5 released", 2, 2);

    // R6 overrun, direct then broadcast
    do_clr; mask = 16'h0100; fb[0] = 8'h38;
    for (int i = 1; i < 17; i++) fb[i] = 8'(i * 13 + 1);
    frame_tx(17);
    check_frame("R6 direct", 17, 0);
    chk("R6 arr_sts", int'(arr_sts), 8'h50);
    do_clr; fb[0] = 8'h3F;
    frame_tx(17);
    check_frame("R6 bcast", 17, 0);

    // R7 start bit held low too long
    do_clr; tx_low = 1'b1; wait_u(50); tx_low = 1'b0; wait_u(60);
    chk("R7 start timeout", int'(flags), 9'h008);

    // R8 data bit timeout mid-byte
    do_clr; bit_tx(37, 45); bit_tx(6, 24); bit_tx(15, 24); wait_u(40);
    chk("R8 data timeout", int'(flags), 9'h010);

    // R9 high pulse too short, then low pulse too short
    do_clr; bit_tx(37, 45); bit_tx(22, 24); bit_tx(6, 24); wait_u(60);
    chk("R9 hpulse", int'(flags), 9'h040);
    do_clr; bit_tx(37, 45); bit_tx(2, 24); wait_u(60);
    chk("R9 lpulse", int'(flags), 9'h020);

    // R10 short and long periods inside an accepted frame
    do_clr; mask = 16'h0002; fb[0] = 8'h01;
    bit_tx(37, 45); byte_tx(fb[0], 1'b0, ack_seen[0]); bit_tx(6, 18); bit_tx(6, 24); wait_u(60);
    chk("R10 short", int'(flags), 9'h082);
    do_clr; bit_tx(37, 45); byte_tx(fb[0], 1'b0, ack_seen[0]); bit_tx(6, 27); bit_tx(6, 24); wait_u(60);
    chk("R10 long", int'(flags), 9'h102);

    // R11 glitch with filter on, then off
    do_clr; filt = 1'b1;
    tx_low = 1'b1; repeat (2) @(negedge clk); tx_low = 1'b0; wait_u(20);
    chk("R11 filtered", int'(flags), 0);
    filt = 1'b0;
    tx_low = 1'b1; repeat (2) @(negedge clk); tx_low = 1'b0; wait_u(20);
    chk("R11 unfiltered", int'(flags), 9'h020);

    // R12 clear
    do_clr; @(negedge clk);
    chk("R12 clear", int'(flags), 0);

    // random frames: R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      int len;
      do_clr;
      mask = 16'($urandom);
      filt = 1'($urandom);
      len  = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
      cb = int'(arr_sts[4:0]);
      frame_tx(len);
      check_frame("R2 R5 random", len, cb);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule